// File: doc/BRIEF.md
# Page DMA Transfer Sequencer

This block moves one NAND cache page between a serial NAND device and system memory with no processor involvement. Software sets up the direction, the command opcode, the lane mode, the memory start address and the byte count in configuration fields. It then raises a trigger bit. For a read, the sequencer sends the read-from-cache opcode, a two-byte zero column address and dummy bytes. It then writes every received byte to the memory write port. For a program load, it sends the opcode and the zero column address. It then fetches each byte from the memory read port and sends it to the device.

The serial shifter sits outside this block. It sees a byte-wide transmit and receive handshake, a frame-active level and a lane-mode code that tells it how many data lanes to use. Completion is reported on two sides, each with its own flag. One flag covers the device-side cache transfer and the other covers the memory-bus side. A busy level is raised for the length of a transfer.

Top module: `snd_page_dma`

## Requirements
- R1: A transfer starts only on a 0-to-1 transition of a trigger while the engine is idle. A read starts on `ctl_rd_trig` with `cfg_dma_en`=1, `cfg_read_dir`=1 and `cfg_opmode`=6. A program load starts on `ctl_wr_trig` with `cfg_dma_en`=1, `cfg_read_dir`=0 and `cfg_opmode`=3. Any other configuration, or a trigger held high, starts nothing.
- R2: `busy` is high from the clock edge that accepts a start until the transfer ends. A trigger edge that arrives while busy is ignored and does not restart the header.
- R3: Every transfer first sends its opcode, then two 0x00 column bytes. A read then sends `HDR_DUMMY_BYTES` bytes of 0xFF. `spi_cs_active` is high for the whole transfer.
- R4: For a read, received byte i is written to memory at address base + i*`ADDR_STEP`, in arrival order, with its value unchanged.
- R5: For a program load, byte i is read from memory at base + i*`ADDR_STEP` and sent to the device in order, after the header.
- R6: `spi_lane_mode` is 0 (single) during the header. During read data it is 1 if the lane field is 1, 2 if the lane field is 2, and 0 for any other value. During program data it is 2 when bit 1 of the lane field is set, and 0 otherwise.
- R7: For a read, `cache_rd_done` rises when the last byte is received. `bus_done` rises, and `busy` falls, when the last memory write is acknowledged.
- R8: For a program load, `bus_done` rises when the last memory read data returns. `cache_ld_done` rises, and `busy` falls, when the device accepts the last byte. `cache_ld_done` never rises before `bus_done`.
- R9: A one-cycle pulse on `clr_cache_rd_done` or `clr_cache_ld_done` clears only that flag. Accepting a new start clears all three done flags.
- R10: A byte count of zero sends only the header, then sets both completion flags of that direction.
- R11: `ctl_flush` or `ctl_engine_rst` aborts any transfer to idle in the next cycle and drops held data. `ctl_engine_rst` also clears the done flags, while `ctl_flush` leaves them unchanged.
- R12: After reset, `busy`, all done flags, `spi_cs_active` and every valid output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_dma_en | input | 1 | Engine enable |
| cfg_read_dir | input | 1 | 1 = device to memory |
| cfg_opmode | input | 3 | Operation code (6 read, 3 program) |
| cfg_lane_mode | input | 3 | Data lane field |
| cfg_rd_count | input | COUNT_W | Read byte count |
| cfg_pg_count | input | COUNT_W | Program byte count |
| cfg_rd_opcode | input | 8 | Read-from-cache opcode |
| cfg_pg_opcode | input | 8 | Program-load opcode |
| cfg_mem_base | input | ADDR_W | Memory start address |
| ctl_rd_trig | input | 1 | Read trigger level |
| ctl_wr_trig | input | 1 | Program trigger level |
| ctl_flush | input | 1 | Drop data and abort |
| ctl_engine_rst | input | 1 | Abort and clear flags |
| clr_cache_rd_done | input | 1 | Write-one-clear pulse, read flag |
| clr_cache_ld_done | input | 1 | Write-one-clear pulse, load flag |
| spi_cs_active | output | 1 | Device frame active |
| spi_lane_mode | output | 2 | 0 single, 1 dual, 2 quad |
| spi_tx_valid | output | 1 | Transmit byte valid |
| spi_tx_ready | input | 1 | Shifter takes byte |
| spi_tx_data | output | 8 | Transmit byte |
| spi_rx_valid | input | 1 | Received byte valid |
| spi_rx_ready | output | 1 | Sequencer takes byte |
| spi_rx_data | input | 8 | Received byte |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory takes write |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | 8 | Write data |
| mem_wr_ack | input | 1 | Write completion pulse |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory takes read |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_rvalid | input | 1 | Read data return |
| mem_rd_rdata | input | 8 | Read data |
| busy | output | 1 | Transfer in progress |
| cache_rd_done | output | 1 | Read-from-cache finished |
| cache_ld_done | output | 1 | Load-to-cache finished |
| bus_done | output | 1 | Memory side finished |

## Verification
The bench sweeps both directions over zero, one, two and five bytes, every lane code and stalling or free-flowing handshakes. A wrong header length would shift every later byte, and a missed stall would drop or duplicate memory beats. The timing of both completions is checked, and retriggering is checked while busy, with a held level and with a wrong operation mode. A design that took the level rather than the edge would restart at once. One that left the read side on early acknowledgement would raise the bus flag before the memory writes were done. Abort and write-one-clear tests confirm that flush keeps the flags while the engine reset clears them.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_HDR     = 2'd1,
      ST_RD_DATA = 2'd2,
      ST_PG_DATA = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      LANE_X1 = 2'd0,
      LANE_X2 = 2'd1,
      LANE_X4 = 2'd2
   } lane_t;

   localparam logic [2:0] OPMODE_PAGE_READ = 3'd6;
   localparam logic [2:0] OPMODE_PROG_LOAD = 3'd3;

   localparam logic [7:0] COLUMN_BYTE = 8'h00;
   localparam logic [7:0] DUMMY_BYTE  = 8'hFF;

endpackage

// File: rtl/snd_rise_detect.sv
module snd_rise_detect #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] level,
   output logic [N-1:0] rise
);

   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;

endmodule

// File: rtl/snd_beat_counter.sv
module snd_beat_counter #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         at_last,
   output logic         spent
);

   logic [W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count_q <= '0;
      else if (clr) count_q <= '0;
      else if (inc) count_q <= count_q + 1'b1;
   end

   assign at_last = ({1'b0, count_q} + 1'b1) == {1'b0, limit};
   assign spent   = (count_q == limit);

endmodule

// File: rtl/snd_addr_step.sv
module snd_addr_step #(
   parameter int AW   = 32,
   parameter int STEP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   output logic [AW-1:0] addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= base;
      else if (adv)  addr <= addr + AW'(STEP);
   end

endmodule

// File: rtl/snd_page_dma.sv
module snd_page_dma
   import snd_dma_pkg::*;
#(
   parameter int COUNT_W         = 13,
   parameter int ADDR_W          = 32,
   parameter int ADDR_STEP       = 1,
   parameter int HDR_DUMMY_BYTES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_dma_en,
   input  logic               cfg_read_dir,
   input  logic [2:0]         cfg_opmode,
   input  logic [2:0]         cfg_lane_mode,
   input  logic [COUNT_W-1:0] cfg_rd_count,
   input  logic [COUNT_W-1:0] cfg_pg_count,
   input  logic [7:0]         cfg_rd_opcode,
   input  logic [7:0]         cfg_pg_opcode,
   input  logic [ADDR_W-1:0]  cfg_mem_base,
   input  logic               ctl_rd_trig,
   input  logic               ctl_wr_trig,
   input  logic               ctl_flush,
   input  logic               ctl_engine_rst,
   input  logic               clr_cache_rd_done,
   input  logic               clr_cache_ld_done,
   output logic               spi_cs_active,
   output logic [1:0]         spi_lane_mode,
   output logic               spi_tx_valid,
   input  logic               spi_tx_ready,
   output logic [7:0]         spi_tx_data,
   input  logic               spi_rx_valid,
   output logic               spi_rx_ready,
   input  logic [7:0]         spi_rx_data,
   output logic               mem_wr_valid,
   input  logic               mem_wr_ready,
   output logic [ADDR_W-1:0]  mem_wr_addr,
   output logic [7:0]         mem_wr_data,
   input  logic               mem_wr_ack,
   output logic               mem_rd_valid,
   input  logic               mem_rd_ready,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic               mem_rd_rvalid,
   input  logic [7:0]         mem_rd_rdata,
   output logic               busy,
   output logic               cache_rd_done,
   output logic               cache_ld_done,
   output logic               bus_done
);

   localparam int HDR_FIXED = 3;
   localparam int HDR_MAX   = HDR_FIXED + HDR_DUMMY_BYTES;
   localparam int HDR_W     = $clog2(HDR_MAX + 1);
   localparam int N_CNT     = 3;

   if (COUNT_W < 1 || COUNT_W > 16) begin : g_bad_count
      $error("COUNT_W out of range");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small");
   end
   if (ADDR_STEP < 1) begin : g_bad_step
      $error("ADDR_STEP must be positive");
   end
   if (HDR_DUMMY_BYTES < 0 || HDR_DUMMY_BYTES > 8) begin : g_bad_dummy
      $error("HDR_DUMMY_BYTES out of range");
   end

   seq_state_t         state_q;
   logic               is_read_q;
   logic [7:0]         opcode_q;
   logic [COUNT_W-1:0] count_q;
   lane_t              lane_q;
   logic [HDR_W-1:0]   hdr_idx_q;
   logic               hold_v_q;
   logic [7:0]         hold_d_q;
   logic               rd_pend_q;
   logic               rd_done_q, ld_done_q, bus_done_q;

   // Trigger edges: bit 0 read, bit 1 program
   logic [1:0] trig_rise;
   snd_rise_detect #(.N(2)) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .level ({ctl_wr_trig, ctl_rd_trig}),
      .rise  (trig_rise)
   );

   logic abort, idle, start_rd, start_pg, start_any;
   assign abort    = ctl_flush | ctl_engine_rst;
   assign idle     = (state_q == ST_IDLE);
   assign start_rd = idle && !abort && trig_rise[0] && cfg_dma_en && cfg_read_dir
                     && (cfg_opmode == OPMODE_PAGE_READ);
   assign start_pg = idle && !abort && trig_rise[1] && cfg_dma_en && !cfg_read_dir
                     && (cfg_opmode == OPMODE_PROG_LOAD);
   assign start_any = start_rd | start_pg;

   // Header generation
   logic [HDR_W-1:0] hdr_len;
   logic             hdr_last;
   logic [7:0]       hdr_byte;
   assign hdr_len  = is_read_q ? HDR_W'(HDR_MAX) : HDR_W'(HDR_FIXED);
   assign hdr_last = (hdr_idx_q == hdr_len - 1'b1);

   always_comb begin
      if (hdr_idx_q == '0)                   hdr_byte = opcode_q;
      else if (hdr_idx_q < HDR_W'(HDR_FIXED)) hdr_byte = COLUMN_BYTE;
      else                                   hdr_byte = DUMMY_BYTE;
   end

   // Handshake events
   logic in_hdr, in_rd, in_pg;
   assign in_hdr = (state_q == ST_HDR);
   assign in_rd  = (state_q == ST_RD_DATA);
   assign in_pg  = (state_q == ST_PG_DATA);

   logic [N_CNT-1:0] cnt_ev, cnt_last, cnt_spent;
   logic             rx_fire, wr_fire, rd_fire, rret_fire, hdr_fire, ptx_fire;

   assign spi_rx_ready = in_rd && !hold_v_q && !cnt_spent[0];
   assign mem_wr_valid = in_rd && hold_v_q;
   assign mem_rd_valid = in_pg && !rd_pend_q && !hold_v_q && !cnt_spent[0];
   assign spi_tx_valid = in_hdr || (in_pg && hold_v_q);

   assign rx_fire   = spi_rx_ready && spi_rx_valid;
   assign wr_fire   = mem_wr_valid && mem_wr_ready;
   assign rd_fire   = mem_rd_valid && mem_rd_ready;
   assign rret_fire = in_pg && rd_pend_q && mem_rd_rvalid;
   assign hdr_fire  = in_hdr && spi_tx_ready;
   assign ptx_fire  = in_pg && hold_v_q && spi_tx_ready;

   // Counter 0: beats entering (rx or read issue); 1: beats finishing on the
   // memory side (write ack or read return); 2: program bytes sent.
   assign cnt_ev[0] = rx_fire | rd_fire;
   assign cnt_ev[1] = (in_rd && mem_wr_ack) | rret_fire;
   assign cnt_ev[2] = ptx_fire;

   for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
      snd_beat_counter #(.W(COUNT_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (start_any | abort),
         .inc     (cnt_ev[k]),
         .limit   (count_q),
         .at_last (cnt_last[k]),
         .spent   (cnt_spent[k])
      );
   end

   logic [N_CNT-2:0] unused_spent;
   assign unused_spent = cnt_spent[N_CNT-1:1];

   // Memory address generator shared by both directions
   logic [ADDR_W-1:0] addr;
   snd_addr_step #(.AW(ADDR_W), .STEP(ADDR_STEP)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_any),
      .base  (cfg_mem_base),
      .adv   (wr_fire | rd_fire),
      .addr  (addr)
   );
   assign mem_wr_addr = addr;
   assign mem_rd_addr = addr;
   assign mem_wr_data = hold_d_q;

   // Lane decode at start
   lane_t lane_next;
   always_comb begin
      if (cfg_read_dir) begin
         case (cfg_lane_mode)
            3'd1:    lane_next = LANE_X2;
            3'd2:    lane_next = LANE_X4;
            default: lane_next = LANE_X1;
         endcase
      end else begin
         lane_next = cfg_lane_mode[1] ? LANE_X4 : LANE_X1;
      end
   end

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         is_read_q  <= 1'b0;
         opcode_q   <= '0;
         count_q    <= '0;
         lane_q     <= LANE_X1;
         hdr_idx_q  <= '0;
         hold_v_q   <= 1'b0;
         hold_d_q   <= '0;
         rd_pend_q  <= 1'b0;
         rd_done_q  <= 1'b0;
         ld_done_q  <= 1'b0;
         bus_done_q <= 1'b0;
      end else if (abort) begin
         state_q   <= ST_IDLE;
         hold_v_q  <= 1'b0;
         rd_pend_q <= 1'b0;
         if (ctl_engine_rst) begin
            rd_done_q  <= 1'b0;
            ld_done_q  <= 1'b0;
            bus_done_q <= 1'b0;
         end
      end else begin
         if (clr_cache_rd_done) rd_done_q <= 1'b0;
         if (clr_cache_ld_done) ld_done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_any) begin
                  state_q    <= ST_HDR;
                  is_read_q  <= start_rd;
                  opcode_q   <= start_rd ? cfg_rd_opcode : cfg_pg_opcode;
                  count_q    <= start_rd ? cfg_rd_count : cfg_pg_count;
                  lane_q     <= lane_next;
                  hdr_idx_q  <= '0;
                  hold_v_q   <= 1'b0;
                  rd_pend_q  <= 1'b0;
                  rd_done_q  <= 1'b0;
                  ld_done_q  <= 1'b0;
                  bus_done_q <= 1'b0;
               end
            end
            ST_HDR: begin
               if (hdr_fire) begin
                  if (!hdr_last) begin
                     hdr_idx_q <= hdr_idx_q + 1'b1;
                  end else if (count_q == '0) begin
                     state_q    <= ST_IDLE;
                     bus_done_q <= 1'b1;
                     if (is_read_q) rd_done_q <= 1'b1;
                     else           ld_done_q <= 1'b1;
                  end else begin
                     state_q <= is_read_q ? ST_RD_DATA : ST_PG_DATA;
                  end
               end
            end
            ST_RD_DATA: begin
               if (rx_fire) begin
                  hold_v_q <= 1'b1;
                  hold_d_q <= spi_rx_data;
                  if (cnt_last[0]) rd_done_q <= 1'b1;
               end else if (wr_fire) begin
                  hold_v_q <= 1'b0;
               end
               if (mem_wr_ack && cnt_last[1]) begin
                  bus_done_q <= 1'b1;
                  state_q    <= ST_IDLE;
               end
            end
            ST_PG_DATA: begin
               if (rd_fire) rd_pend_q <= 1'b1;
               if (rret_fire) begin
                  rd_pend_q <= 1'b0;
                  hold_v_q  <= 1'b1;
                  hold_d_q  <= mem_rd_rdata;
                  if (cnt_last[1]) bus_done_q <= 1'b1;
               end else if (ptx_fire) begin
                  hold_v_q <= 1'b0;
                  if (cnt_last[2]) begin
                     ld_done_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign spi_cs_active = !idle;
   assign spi_tx_data   = in_hdr ? hdr_byte : hold_d_q;
   assign spi_lane_mode = (in_rd || in_pg) ? lane_q : LANE_X1;
   assign busy          = !idle;
   assign cache_rd_done = rd_done_q;
   assign cache_ld_done = ld_done_q;
   assign bus_done      = bus_done_q;

endmodule

// File: rtl/snd_page_dma_chk.sv
module snd_page_dma_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_flush,
   input logic              ctl_engine_rst,
   input logic              spi_cs_active,
   input logic              spi_tx_valid,
   input logic              mem_wr_valid,
   input logic              mem_wr_ready,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [7:0]        mem_wr_data,
   input logic              mem_rd_valid,
   input logic              mem_rd_ready,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              cache_rd_done,
   input logic              cache_ld_done,
   input logic              bus_done
);

   a_r3_tx_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      spi_tx_valid |-> spi_cs_active);

   a_r4_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready && !ctl_flush && !ctl_engine_rst)
      |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

   a_r5_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready && !ctl_flush && !ctl_engine_rst)
      |=> (mem_rd_valid && $stable(mem_rd_addr)));

   a_r8_bus_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cache_ld_done) |-> bus_done);

   a_r9_one_side: assert property (@(posedge clk) disable iff (!rst_n)
      !(cache_rd_done && cache_ld_done));

   a_r4_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_valid && mem_rd_valid));

endmodule

bind snd_page_dma snd_page_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ctl_flush      (ctl_flush),
   .ctl_engine_rst (ctl_engine_rst),
   .spi_cs_active  (spi_cs_active),
   .spi_tx_valid   (spi_tx_valid),
   .mem_wr_valid   (mem_wr_valid),
   .mem_wr_ready   (mem_wr_ready),
   .mem_wr_addr    (mem_wr_addr),
   .mem_wr_data    (mem_wr_data),
   .mem_rd_valid   (mem_rd_valid),
   .mem_rd_ready   (mem_rd_ready),
   .mem_rd_addr    (mem_rd_addr),
   .cache_rd_done  (cache_rd_done),
   .cache_ld_done  (cache_ld_done),
   .bus_done       (bus_done)
);

// File: tb/test_snd_page_dma.sv
module test_snd_page_dma;

   localparam int CLK_PERIOD = 10;
   localparam int COUNT_W = 13;
   localparam int ADDR_W  = 32;
   localparam int NDUMMY  = 1;
   localparam int HDR_RD  = 3 + NDUMMY;
   localparam int HDR_PG  = 3;

   logic clk = 0, rst_n = 0;
   logic cfg_dma_en = 0, cfg_read_dir = 0;
   logic [2:0] cfg_opmode = 0, cfg_lane_mode = 0;
   logic [COUNT_W-1:0] cfg_rd_count = 0, cfg_pg_count = 0;
   logic [7:0] cfg_rd_opcode = 0, cfg_pg_opcode = 0;
   logic [ADDR_W-1:0] cfg_mem_base = 0;
   logic ctl_rd_trig = 0, ctl_wr_trig = 0, ctl_flush = 0, ctl_engine_rst = 0;
   logic clr_cache_rd_done = 0, clr_cache_ld_done = 0;
   logic spi_cs_active, spi_tx_valid, spi_rx_ready;
   logic [1:0] spi_lane_mode;
   logic spi_tx_ready = 0, spi_rx_valid = 0;
   logic [7:0] spi_tx_data, spi_rx_data = 0;
   logic mem_wr_valid, mem_rd_valid;
   logic mem_wr_ready = 0, mem_wr_ack = 0, mem_rd_ready = 0, mem_rd_rvalid = 0;
   logic [ADDR_W-1:0] mem_wr_addr, mem_rd_addr;
   logic [7:0] mem_wr_data, mem_rd_rdata = 0;
   logic busy, cache_rd_done, cache_ld_done, bus_done;

   snd_page_dma #(.COUNT_W(COUNT_W), .ADDR_W(ADDR_W), .ADDR_STEP(1),
                  .HDR_DUMMY_BYTES(NDUMMY)) i_snd_page_dma (
      .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .cfg_read_dir(cfg_read_dir),
      .cfg_opmode(cfg_opmode), .cfg_lane_mode(cfg_lane_mode),
      .cfg_rd_count(cfg_rd_count), .cfg_pg_count(cfg_pg_count),
      .cfg_rd_opcode(cfg_rd_opcode), .cfg_pg_opcode(cfg_pg_opcode),
      .cfg_mem_base(cfg_mem_base), .ctl_rd_trig(ctl_rd_trig), .ctl_wr_trig(ctl_wr_trig),
      .ctl_flush(ctl_flush), .ctl_engine_rst(ctl_engine_rst),
      .clr_cache_rd_done(clr_cache_rd_done), .clr_cache_ld_done(clr_cache_ld_done),
      .spi_cs_active(spi_cs_active), .spi_lane_mode(spi_lane_mode),
      .spi_tx_valid(spi_tx_valid), .spi_tx_ready(spi_tx_ready), .spi_tx_data(spi_tx_data),
      .spi_rx_valid(spi_rx_valid), .spi_rx_ready(spi_rx_ready), .spi_rx_data(spi_rx_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_rdata(mem_rd_rdata),
      .busy(busy), .cache_rd_done(cache_rd_done), .cache_ld_done(cache_ld_done),
      .bus_done(bus_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0, n_errors = 0;
   int cyc = 0;
   bit stall = 0;
   int tx_n = 0, rx_n = 0, wr_n = 0, rd_n = 0;
   logic [7:0] tx_log [64];
   logic [1:0] tx_lane [64];
   logic       tx_cs [64];
   logic [1:0] rx_lane [64];
   logic [31:0] wr_addr_log [64];
   logic [7:0]  wr_data_log [64];
   logic [31:0] rd_addr_log [64];
   logic [1:0] ack_pipe = 0;
   logic       resp_pend = 0;
   logic [7:0] resp_data = 0;

   function automatic logic [7:0] rx_pat(int i);
      return 8'(8'hA5 ^ (i * 13));
   endfunction

   function automatic logic [7:0] mem_pat(logic [31:0] a);
      return 8'(a * 3 + 1);
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Device and memory models, driven away from the active edge
   always @(negedge clk) begin
      bit wf;
      cyc++;
      spi_tx_ready = stall ? cyc[0] : 1'b1;
      if (spi_tx_valid && spi_tx_ready && tx_n < 64) begin
         tx_log[tx_n] = spi_tx_data;
         tx_lane[tx_n] = spi_lane_mode;
         tx_cs[tx_n] = spi_cs_active;
         tx_n++;
      end
      spi_rx_valid = 1'b1;
      spi_rx_data = rx_pat(rx_n);
      if (spi_rx_valid && spi_rx_ready && rx_n < 64) begin
         rx_lane[rx_n] = spi_lane_mode;
         rx_n++;
      end
      mem_wr_ready = stall ? cyc[1] : 1'b1;
      wf = mem_wr_valid && mem_wr_ready;
      mem_wr_ack = ack_pipe[1];
      ack_pipe = {ack_pipe[0], wf};
      if (wf && wr_n < 64) begin
         wr_addr_log[wr_n] = mem_wr_addr;
         wr_data_log[wr_n] = mem_wr_data;
         wr_n++;
      end
      mem_rd_rvalid = resp_pend;
      mem_rd_rdata = resp_data;
      resp_pend = 0;
      mem_rd_ready = stall ? cyc[1] : 1'b1;
      if (mem_rd_valid && mem_rd_ready && rd_n < 64) begin
         rd_addr_log[rd_n] = mem_rd_addr;
         rd_n++;
         resp_pend = 1;
         resp_data = mem_pat(mem_rd_addr);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic setup(bit rd, int cnt, logic [2:0] lane, logic [31:0] base, logic [7:0] op);
      step(1);
      ctl_rd_trig = 0; ctl_wr_trig = 0;
      cfg_dma_en = 1; cfg_read_dir = rd;
      cfg_opmode = rd ? 3'd6 : 3'd3;
      cfg_lane_mode = lane;
      cfg_rd_count = COUNT_W'(cnt); cfg_pg_count = COUNT_W'(cnt);
      cfg_rd_opcode = op; cfg_pg_opcode = op ^ 8'h55;
      cfg_mem_base = base;
      step(1);
      tx_n = 0; rx_n = 0; wr_n = 0; rd_n = 0;
   endtask

   task automatic fire(bit rd);
      if (rd) ctl_rd_trig = 1; else ctl_wr_trig = 1;
      step(1);
   endtask

   task automatic wait_idle();
      int g = 0;
      while (busy && g < 5000) begin
         step(1);
         g++;
      end
   endtask

   task automatic run_check(bit rd, int cnt, logic [2:0] lane, logic [31:0] base, logic [7:0] op);
      int hdr;
      logic [1:0] exp_lane;
      logic [7:0] exp_op;
      hdr = rd ? HDR_RD : HDR_PG;
      exp_op = rd ? op : (op ^ 8'h55);
      if (rd) exp_lane = (lane == 3'd1) ? 2'd1 : (lane == 3'd2) ? 2'd2 : 2'd0;
      else    exp_lane = lane[1] ? 2'd2 : 2'd0;
      setup(rd, cnt, lane, base, op);
      fire(rd);
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      wait_idle();
      chk(busy == 1'b0, "R2 busy ends", busy, 0);
      // R3 header
      chk(tx_n == hdr + (rd ? 0 : cnt), "R3 tx byte total", tx_n, hdr + (rd ? 0 : cnt));
      chk(tx_log[0] == exp_op, "R3 opcode byte", tx_log[0], exp_op);
      chk(tx_log[1] == 8'h00 && tx_log[2] == 8'h00, "R3 column bytes",
          {tx_log[1], tx_log[2]}, 0);
      if (rd) chk(tx_log[3] == 8'hFF, "R3 dummy byte", tx_log[3], 8'hFF);
      for (int i = 0; i < hdr; i++) begin
         chk(tx_lane[i] == 2'd0 && tx_cs[i], "R6 header single lane in frame",
             {tx_cs[i], tx_lane[i]}, 3'b100);
      end
      if (rd) begin
         chk(rx_n == cnt, "R4 bytes received", rx_n, cnt);
         chk(wr_n == cnt, "R4 memory writes", wr_n, cnt);
         for (int i = 0; i < cnt; i++) begin
            chk(wr_addr_log[i] == base + 32'(i), "R4 write address", wr_addr_log[i], base + 32'(i));
            chk(wr_data_log[i] == rx_pat(i), "R4 write data", wr_data_log[i], rx_pat(i));
            chk(rx_lane[i] == exp_lane, "R6 read data lane", rx_lane[i], exp_lane);
         end
         chk(cache_rd_done && bus_done && !cache_ld_done,
             cnt == 0 ? "R10 read zero-count flags" : "R7 read completion flags",
             {cache_rd_done, bus_done, cache_ld_done}, 3'b110);
      end else begin
         chk(rd_n == cnt, "R5 memory reads", rd_n, cnt);
         for (int i = 0; i < cnt; i++) begin
            chk(rd_addr_log[i] == base + 32'(i), "R5 read address", rd_addr_log[i], base + 32'(i));
            chk(tx_log[hdr+i] == mem_pat(base + 32'(i)), "R5 sent data",
                tx_log[hdr+i], mem_pat(base + 32'(i)));
            chk(tx_lane[hdr+i] == exp_lane, "R6 program data lane", tx_lane[hdr+i], exp_lane);
         end
         chk(cache_ld_done && bus_done && !cache_rd_done,
             cnt == 0 ? "R10 program zero-count flags" : "R8 program completion flags",
             {cache_rd_done, bus_done, cache_ld_done}, 3'b011);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      int counts [4] = '{0, 1, 2, 5};
      step(3);
      rst_n = 1;
      step(1);
      // R12 reset state
      chk(!busy && !cache_rd_done && !cache_ld_done && !bus_done, "R12 flags after reset",
          {busy, cache_rd_done, cache_ld_done, bus_done}, 0);
      chk(!spi_cs_active && !spi_tx_valid && !mem_wr_valid && !mem_rd_valid,
          "R12 outputs after reset",
          {spi_cs_active, spi_tx_valid, mem_wr_valid, mem_rd_valid}, 0);

      // Sweep both directions, counts, lane codes, stalls
      for (int d = 1; d >= 0; d--) begin
         for (int c = 0; c < 4; c++) begin
            for (int l = 0; l < 4; l++) begin
               stall = ((c + l) % 2) == 1;
               run_check(d[0], counts[c], 3'(l), 32'h100 * (l + 1) + 32'(c), 8'h6B);
            end
         end
      end
      stall = 0;

      // R1: held trigger level does not restart
      step(5);
      chk(!busy && tx_n == HDR_PG + 5, "R1 held level no restart", tx_n, HDR_PG + 5);

      // R1: wrong operation mode, disabled engine
      setup(1, 2, 0, 32'h40, 8'h03);
      cfg_opmode = 3'd5;
      fire(1);
      step(3);
      chk(!busy && tx_n == 0, "R1 wrong mode ignored", {busy, 8'(tx_n)}, 0);
      setup(0, 2, 0, 32'h40, 8'h02);
      cfg_dma_en = 0;
      fire(0);
      step(3);
      chk(!busy && tx_n == 0, "R1 disabled engine ignored", {busy, 8'(tx_n)}, 0);
      setup(1, 2, 0, 32'h40, 8'h03);
      fire(0);
      step(3);
      chk(!busy && tx_n == 0, "R1 wrong trigger for direction", {busy, 8'(tx_n)}, 0);

      // R2: retrigger while busy ignored
      stall = 1;
      setup(1, 5, 0, 32'h200, 8'h0B);
      fire(1);
      ctl_rd_trig = 0;
      step(1);
      ctl_rd_trig = 1;
      step(1);
      wait_idle();
      chk(tx_n == HDR_RD, "R2 header sent once", tx_n, HDR_RD);
      chk(wr_n == 5, "R2 beat count kept", wr_n, 5);
      stall = 0;

      // R9: write-one-clear and clear on new start
      clr_cache_rd_done = 1;
      step(1);
      clr_cache_rd_done = 0;
      chk(!cache_rd_done && bus_done, "R9 clear read flag only",
          {cache_rd_done, bus_done}, 2'b01);
      run_check(1, 1, 0, 32'h300, 8'h03);
      setup(0, 3, 0, 32'h310, 8'h32);
      fire(0);
      chk(!cache_rd_done && !bus_done, "R9 start clears flags", {cache_rd_done, bus_done}, 0);
      wait_idle();
      clr_cache_ld_done = 1;
      step(1);
      clr_cache_ld_done = 0;
      chk(!cache_ld_done && bus_done, "R9 clear load flag only",
          {cache_ld_done, bus_done}, 2'b01);

      // R11: flush mid transfer, flush keeps flags, engine reset clears them
      stall = 1;
      setup(1, 5, 0, 32'h400, 8'h0B);
      fire(1);
      step(3);
      ctl_flush = 1;
      step(1);
      ctl_flush = 0;
      chk(!busy && !spi_cs_active && !mem_wr_valid, "R11 flush aborts",
          {busy, spi_cs_active, mem_wr_valid}, 0);
      stall = 0;
      step(4);
      chk(!busy, "R11 stays idle after abort", busy, 0);
      run_check(1, 2, 0, 32'h500, 8'h03);
      ctl_flush = 1;
      step(1);
      ctl_flush = 0;
      chk(cache_rd_done && bus_done, "R11 flush keeps flags", {cache_rd_done, bus_done}, 2'b11);
      ctl_engine_rst = 1;
      step(1);
      ctl_engine_rst = 0;
      chk(!cache_rd_done && !bus_done, "R11 engine reset clears flags",
          {cache_rd_done, bus_done}, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule